// File: doc/BRIEF.md
# Tree-structured wide magnitude comparator

The block judges two unsigned words and reports whether the first is greater than, equal to or less than the second. It does not run a serial chain of narrow cascadable comparators. It arranges them in two levels. The first level is a bank of small comparator cells, each judging one slice of the words. Each cell's greater and less verdicts then become one operand bit pair of a single final cell.

Every cell has three expander inputs that resolve a tie on its data bits. On the least significant slice these inputs take the start-of-chain values (greater low, equal high, less low). On every other slice they are reused as a fifth data position below the slice's four data bits. The extra A bit goes to the greater input, the extra B bit goes to the less input, and the equal input is tied low.

A tie in that reused position can leave both the greater and less outputs high. That is harmless only because those outputs drive data bits of the final cell. The least significant slice's full verdict drives the final cell's expander inputs.

With a cell width of 4 this gives five first-level cells and one final cell, covering 24 bits. A narrower word is zero-extended. The verdict is registered, so it appears one clock after the operands are sampled.

Top module: `wide_cmp_tree`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three outputs are low after that edge.
- R2: After any edge with `rst` low, exactly one of `gt_o`, `eq_o`, `lt_o` is high.
- R3: `gt_o` is high one clock after an edge at which `a_i` > `b_i` (unsigned).
- R4: `lt_o` is high one clock after an edge at which `a_i` < `b_i` (unsigned).
- R5: `eq_o` is high one clock after an edge exactly when `a_i` equals `b_i` at that edge.
- R6: A difference in a single bit at any of the 24 positions is resolved in favour of the word holding the 1, whatever the other, identical bits hold.
- R7: Bits 4, 9, 14 and 19 (the reused expander positions) and the four data bits above each of them are weighted in true binary order. This holds for every value pair in such a 5-bit slice while all other bits are equal, and includes ties in the reused bit with value 0 and with value 1.
- R8: When bits 23..4 are equal, the verdict follows bits 3..0 for every value pair in them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands sampled and verdict updated on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | WIDTH (24) | First operand, unsigned |
| b_i | input | WIDTH (24) | Second operand, unsigned |
| gt_o | output | 1 | Registered: first operand greater |
| eq_o | output | 1 | Registered: operands equal |
| lt_o | output | 1 | Registered: first operand less |

## Verification
The bench sweeps every value pair of each 5-bit slice that uses a reused expander position. A wiring that swapped the extra A and B bits, or tied their equal input high, would misorder those slices. A tie at 0 in that position drives both first-level outputs high, and a design that passed those outputs into expander inputs rather than data bits would report a false inequality or a non-one-hot result.

The low slice is swept exhaustively to expose a wrong start-of-chain tie-off. Single-bit differences at all 24 positions catch slices fed to the final cell in the wrong significance order. Random pairs and extreme values cover general operation.

// File: rtl/wide_cmp_pkg.sv
package wide_cmp_pkg;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } verdict_t;

  // Word width covered by one low slice of CW bits plus CW upper slices of CW+1 bits
  function automatic int tree_width(input int cw);
    return cw * (cw + 2);
  endfunction

  localparam verdict_t CHAIN_START = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/mag_cell.sv
module mag_cell
  import wide_cmp_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  input  verdict_t      seed,
  output verdict_t      res
);

  always_comb begin
    if (a > b) begin
      res = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
    end else if (a < b) begin
      res = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};
    end else begin
      // data tie: the expander inputs decide
      res.gt = ~seed.lt & ~seed.eq;
      res.lt = ~seed.gt & ~seed.eq;
      res.eq = seed.eq;
    end
  end

endmodule

// File: rtl/slice_bank.sv
module slice_bank
  import wide_cmp_pkg::*;
#(
  parameter int CW = 4,
  localparam int FW = tree_width(CW)
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output verdict_t      low_v,
  output logic [CW-1:0] hi_gt,
  output logic [CW-1:0] hi_lt
);

  logic [CW-1:0] unused_hi_eq;

  // least significant slice: start-of-chain tie-off
  mag_cell #(.CW(CW)) u_low (
    .a   (a[CW-1:0]),
    .b   (b[CW-1:0]),
    .seed(CHAIN_START),
    .res (low_v)
  );

  // upper slices: expander inputs carry one extra, lower-order bit
  for (genvar k = 0; k < CW; k++) begin : g_hi
    localparam int BASE = CW + k * (CW + 1);
    verdict_t seed_k;
    verdict_t res_k;

    assign seed_k = '{gt: a[BASE], eq: 1'b0, lt: b[BASE]};

    mag_cell #(.CW(CW)) u_cell (
      .a   (a[BASE+CW:BASE+1]),
      .b   (b[BASE+CW:BASE+1]),
      .seed(seed_k),
      .res (res_k)
    );

    assign hi_gt[k]        = res_k.gt;
    assign hi_lt[k]        = res_k.lt;
    assign unused_hi_eq[k] = res_k.eq;
  end

endmodule

// File: rtl/wide_cmp_tree.sv
module wide_cmp_tree
  import wide_cmp_pkg::*;
#(
  parameter int CELL_W = 4,
  parameter int WIDTH  = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);

  localparam int FULL_W = tree_width(CELL_W);

  logic [FULL_W-1:0] a_full;
  logic [FULL_W-1:0] b_full;
  verdict_t          low_v;
  verdict_t          fin_v;
  logic [CELL_W-1:0] hi_gt;
  logic [CELL_W-1:0] hi_lt;

  assign a_full = FULL_W'(a_i);
  assign b_full = FULL_W'(b_i);

  slice_bank #(.CW(CELL_W)) u_bank (
    .a    (a_full),
    .b    (b_full),
    .low_v(low_v),
    .hi_gt(hi_gt),
    .hi_lt(hi_lt)
  );

  // final level: upper verdicts as operand bits, low slice through expanders
  mag_cell #(.CW(CELL_W)) u_final (
    .a   (hi_gt),
    .b   (hi_lt),
    .seed(low_v),
    .res (fin_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gt_o <= 1'b0;
      eq_o <= 1'b0;
      lt_o <= 1'b0;
    end else begin
      gt_o <= fin_v.gt;
      eq_o <= fin_v.eq;
      lt_o <= fin_v.lt;
    end
  end

endmodule

// File: rtl/wide_cmp_chk.sv
module wide_cmp_chk #(
  parameter int CELL_W = 4,
  parameter int WIDTH  = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             gt_o,
  input logic             eq_o,
  input logic             lt_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!gt_o && !eq_o && !lt_o));

  // R2
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones({gt_o, eq_o, lt_o}) == 1));

  // R3
  gt_chk: assert property (@(posedge clk) disable iff (rst)
    (a_i > b_i) |=> gt_o);

  // R4
  lt_chk: assert property (@(posedge clk) disable iff (rst)
    (a_i < b_i) |=> lt_o);

  // R5
  eq_chk: assert property (@(posedge clk) disable iff (rst)
    (a_i == b_i) |=> eq_o);

endmodule

bind wide_cmp_tree wide_cmp_chk #(.CELL_W(CELL_W), .WIDTH(WIDTH)) u_chk (
  .clk (clk),
  .rst (rst),
  .a_i (a_i),
  .b_i (b_i),
  .gt_o(gt_o),
  .eq_o(eq_o),
  .lt_o(lt_o)
);

// File: tb/sim_wide_cmp_tree.sv
module sim_wide_cmp_tree;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         gt, eq, lt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wide_cmp_tree #(.CELL_W(4), .WIDTH(W)) u0 (
    .clk (clk), .rst (rst), .a_i (a), .b_i (b),
    .gt_o(gt), .eq_o(eq), .lt_o(lt)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h got gt/eq/lt=%b expected %b", tag, a, b, act, exp);
    end
  endtask

  // drive at falling edge, register at next rising edge, sample at the falling edge after
  task automatic step(input logic [W-1:0] va, input logic [W-1:0] vb, input string tag);
    logic [2:0] exp;
    @(negedge clk);
    a = va;
    b = vb;
    @(posedge clk);
    @(negedge clk);
    exp = {va > vb, va == vb, va < vb};
    check(tag, {gt, eq, lt}, exp);
    checks++;
    if ($countones({gt, eq, lt}) != 1) begin
      errors++;
      $display("FAIL R2 got gt/eq/lt=%b expected exactly one high", {gt, eq, lt});
    end
  endtask

  task automatic step_rel(input logic [W-1:0] va, input logic [W-1:0] vb);
    if (va > vb)      step(va, vb, "R3");
    else if (va < vb) step(va, vb, "R4");
    else              step(va, vb, "R5");
  endtask

  initial begin
    logic [W-1:0] base;
    // R1: reset state
    @(negedge clk);
    a = 24'h00_00FF;
    b = 24'h00_0001;
    @(posedge clk);
    @(negedge clk);
    check("R1", {gt, eq, lt}, 3'b000);
    rst = 1'b0;

    // extremes
    step('0, '0, "R5");
    step({W{1'b1}}, {W{1'b1}}, "R5");
    step({W{1'b1}}, '0, "R3");
    step('0, {W{1'b1}}, "R4");
    step({W{1'b1}}, {W{1'b1}} - 1'b1, "R3");
    step(24'h80_0000, 24'h7F_FFFF, "R3");
    step(24'h7F_FFFF, 24'h80_0000, "R4");

    // R6: single-bit difference at every position, both directions
    for (int i = 0; i < W; i++) begin
      base = W'($urandom());
      step(base | (W'(1) << i), base & ~(W'(1) << i), "R6");
      step(base & ~(W'(1) << i), base | (W'(1) << i), "R6");
    end

    // R7: each 5-bit slice with a reused expander bit, all 1024 pairs
    for (int k = 0; k < 4; k++) begin
      for (int x = 0; x < 32; x++) begin
        for (int y = 0; y < 32; y++) begin
          int lo;
          logic [W-1:0] m;
          lo = 4 + k * 5;
          m = W'(31) << lo;
          base = W'($urandom());
          step((base & ~m) | (W'(x) << lo), (base & ~m) | (W'(y) << lo), "R7");
        end
      end
    end

    // R8: low slice, all 256 pairs with upper bits equal
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        base = W'($urandom()) & ~W'(15);
        step(base | W'(x), base | W'(y), "R8");
      end
    end

    // random pairs, half of them sharing upper bits
    for (int n = 0; n < 1000; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom());
      rb = W'($urandom());
      if (n[0]) rb = (ra & 24'hFF_F000) | (rb & 24'h00_0FFF);
      step_rel(ra, rb);
    end

    // R1: reset mid-run with unequal operands
    @(negedge clk);
    a = 24'h12_3456;
    b = 24'h12_3455;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", {gt, eq, lt}, 3'b000);
    rst = 1'b0;
    step(24'h12_3456, 24'h12_3455, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule